// File: doc/BRIEF.md
# Layer-2 Address Learning and Forwarding Table

This block is a small associative table for a Layer-2 switch. Each entry holds one 48-bit station address and the port on which that station was last seen. For every frame presented with a valid strobe, the block runs two searches on the same table in the same cycle.

The destination search decides where the frame goes. A hit returns the stored egress port. A miss raises a flood flag instead. The source search learns where the sender lives. If the sender is unknown, it is written into the table. If the sender is known, its port is refreshed.

All entries sit in flip-flops and are compared in parallel, so a search costs the same whatever the occupancy. The block accepts one frame descriptor every clock, with no stall. The forwarding result appears on the registered outputs one cycle after the descriptor.

When the table is full, a new station replaces the entry under a round-robin pointer. Within a single cycle the forwarding read sees the table as it was before that cycle's learning write. A station therefore becomes visible to lookups from the next frame on.

Top module: `mac_learn_table`

## Requirements
- R1: After reset the table is empty and `fwd_valid` is 0. The first destination lookup after reset misses.
- R2: `fwd_valid` is 1 in the cycle after a cycle with `in_valid` = 1, and 0 in the cycle after a cycle with `in_valid` = 0. This allows one frame per clock with no gaps.
- R3: A destination address that is present in the table gives `fwd_hit` = 1, `fwd_flood` = 0 and `fwd_port` equal to the port stored for that address.
- R4: A destination address that is absent gives `fwd_hit` = 0, `fwd_flood` = 1 and `fwd_port` = 0.
- R5: An unknown source address is written, with the ingress port, into the free entry of lowest index. Entries, once valid, stay valid.
- R6: A known source address arriving on its stored port leaves the table unchanged and uses no new entry.
- R7: A known source address arriving on a different port overwrites that entry's port (station move). No second entry is created for the address.
- R8: An unknown source address arriving when all entries are valid replaces the entry under a round-robin pointer. The pointer starts at entry 0 after reset, advances by one on each such replacement, and wraps from DEPTH-1 to 0.
- R9: When the destination lookup and the learning write touch the same address in one cycle, the lookup returns the table contents from before that write. The next frame sees the written value.
- R10: Cycles with `in_valid` = 0 leave the table unchanged, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame descriptor is present this cycle |
| in_dmac | input | 48 | Destination station address |
| in_smac | input | 48 | Source station address |
| in_port | input | PORT_W | Port the frame arrived on |
| fwd_valid | output | 1 | Forwarding result is valid |
| fwd_hit | output | 1 | Destination address was found |
| fwd_flood | output | 1 | Destination address unknown; send to all ports |
| fwd_port | output | PORT_W | Egress port on a hit, 0 on a miss |

## Verification
The bench sends a frame whose source and destination are the same unknown station. A design that forwarded the value being written in that cycle would report a hit where a flood is due. Back-to-back frames check that a station learned in one cycle is found by the very next frame; a design with an extra pipeline stage would flood it.

The bench then fills the table and keeps learning past its end. A design with a wrong replacement pointer or a missing wrap would evict the wrong station, which shows up as a flood for an address that should remain or a hit for one that should be gone.

Station moves, repeated learning on the same port and idle cycles with garbage on the inputs are also exercised. A design that duplicated an entry or learned while idle would shift the later eviction order.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
    localparam int ADDR_W = 48;
    typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/mlt_match.sv
// Parallel compare of one search key against every stored address.
module mlt_match #(
    parameter int N = 16
) (
    input  mlt_pkg::addr_t             key,
    input  logic [N*mlt_pkg::ADDR_W-1:0] addrs,
    input  logic [N-1:0]               vld,
    output logic [N-1:0]               hit
);
    localparam int AW = mlt_pkg::ADDR_W;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = vld[g] && (addrs[g*AW +: AW] == key);
    end
endmodule

// File: rtl/mlt_first.sv
// Lowest-index set bit of a vector, with an any-set flag.
module mlt_first #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mac_learn_table.sv
module mac_learn_table #(
    parameter int DEPTH  = 16,
    parameter int PORT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [47:0]          in_dmac,
    input  logic [47:0]          in_smac,
    input  logic [PORT_W-1:0]    in_port,
    output logic                 fwd_valid,
    output logic                 fwd_hit,
    output logic                 fwd_flood,
    output logic [PORT_W-1:0]    fwd_port
);
    localparam int AW    = mlt_pkg::ADDR_W;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic              vld;
        mlt_pkg::addr_t    addr;
        logic [PORT_W-1:0] port;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0]  tbl;
        logic [IDX_W-1:0]  rr;
        logic              ov;
        logic              oh;
        logic [PORT_W-1:0] op;
    } st_t;

    st_t st_d, st_q;

    logic [DEPTH*AW-1:0] addr_vec;
    logic [DEPTH-1:0]    vld_vec;
    logic [DEPTH-1:0]    d_hit, s_hit;
    logic [IDX_W-1:0]    d_idx, s_idx, f_idx;
    logic                d_any, s_any, f_any;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            addr_vec[i*AW +: AW] = st_q.tbl[i].addr;
            vld_vec[i]           = st_q.tbl[i].vld;
        end
    end

    mlt_match #(.N(DEPTH)) u_dmatch (
        .key(in_dmac), .addrs(addr_vec), .vld(vld_vec), .hit(d_hit)
    );
    mlt_match #(.N(DEPTH)) u_smatch (
        .key(in_smac), .addrs(addr_vec), .vld(vld_vec), .hit(s_hit)
    );

    mlt_first #(.N(DEPTH), .IDX_W(IDX_W)) u_denc (
        .vec(d_hit), .idx(d_idx), .any(d_any)
    );
    mlt_first #(.N(DEPTH), .IDX_W(IDX_W)) u_senc (
        .vec(s_hit), .idx(s_idx), .any(s_any)
    );
    mlt_first #(.N(DEPTH), .IDX_W(IDX_W)) u_free (
        .vec(~vld_vec), .idx(f_idx), .any(f_any)
    );

    // Lookup reads st_q (pre-write contents); learning writes st_d.
    always_comb begin
        st_d    = st_q;
        st_d.ov = in_valid;
        st_d.oh = 1'b0;
        st_d.op = '0;
        if (in_valid) begin
            st_d.oh = d_any;
            if (d_any) begin
                st_d.op = st_q.tbl[d_idx].port;
            end
            if (s_any) begin
                if (st_q.tbl[s_idx].port != in_port) begin
                    st_d.tbl[s_idx].port = in_port;
                end
            end else if (f_any) begin
                st_d.tbl[f_idx].vld  = 1'b1;
                st_d.tbl[f_idx].addr = in_smac;
                st_d.tbl[f_idx].port = in_port;
            end else begin
                st_d.tbl[st_q.rr].vld  = 1'b1;
                st_d.tbl[st_q.rr].addr = in_smac;
                st_d.tbl[st_q.rr].port = in_port;
                st_d.rr = (st_q.rr == LAST) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fwd_valid = st_q.ov;
    assign fwd_hit   = st_q.oh;
    assign fwd_flood = st_q.ov & ~st_q.oh;
    assign fwd_port  = st_q.op;
endmodule

// File: rtl/mlt_checker.sv
module mlt_checker #(
    parameter int DEPTH  = 16,
    parameter int PORT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              fwd_valid,
    input logic              fwd_hit,
    input logic              fwd_flood,
    input logic [PORT_W-1:0] fwd_port,
    input logic [DEPTH-1:0]  vld_vec,
    input logic [DEPTH-1:0]  s_hit
);
    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> fwd_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !fwd_valid);

    // R4
    hit_flood_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (fwd_hit ^ fwd_flood));

    // R4
    flood_port_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_flood |-> (fwd_port == '0));

    // R10
    idle_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(vld_vec));

    // R5
    entry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((vld_vec & $past(vld_vec)) == $past(vld_vec)));

    // R5
    one_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ($countones(vld_vec) <= $countones($past(vld_vec)) + 1));

    // R7
    unique_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> $onehot0(s_hit));
endmodule

bind mac_learn_table mlt_checker #(.DEPTH(DEPTH), .PORT_W(PORT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .fwd_valid(fwd_valid), .fwd_hit(fwd_hit), .fwd_flood(fwd_flood),
    .fwd_port(fwd_port), .vld_vec(vld_vec), .s_hit(s_hit)
);

// File: tb/mac_learn_table_test.sv
module mac_learn_table_test;
    localparam int DEPTH  = 16;
    localparam int PORT_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [47:0]       in_dmac = '0;
    logic [47:0]       in_smac = '0;
    logic [PORT_W-1:0] in_port = '0;
    logic              fwd_valid, fwd_hit, fwd_flood;
    logic [PORT_W-1:0] fwd_port;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // spec model of the table
    bit          m_vld  [DEPTH];
    logic [47:0] m_addr [DEPTH];
    int          m_port [DEPTH];
    int          m_rr;

    always #5 clk = ~clk;

    mac_learn_table #(.DEPTH(DEPTH), .PORT_W(PORT_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_dmac(in_dmac), .in_smac(in_smac), .in_port(in_port),
        .fwd_valid(fwd_valid), .fwd_hit(fwd_hit),
        .fwd_flood(fwd_flood), .fwd_port(fwd_port)
    );

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic int m_find(logic [47:0] a);
        for (int i = 0; i < DEPTH; i++)
            if (m_vld[i] && m_addr[i] == a) return i;
        return -1;
    endfunction

    task automatic m_learn(logic [47:0] a, int p);
        int k;
        k = m_find(a);
        if (k >= 0) begin
            m_port[k] = p;
            return;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (!m_vld[i]) begin
                m_vld[i] = 1'b1; m_addr[i] = a; m_port[i] = p;
                return;
            end
        end
        m_addr[m_rr] = a; m_port[m_rr] = p;
        m_rr = (m_rr + 1) % DEPTH;
    endtask

    // Drive one frame at a falling edge; check its result at the next one.
    task automatic send(string req, logic [47:0] d, logic [47:0] s, int p);
        int k;
        bit eh;
        int ep;
        k  = m_find(d);
        eh = (k >= 0);
        ep = eh ? m_port[k] : 0;
        m_learn(s, p);
        in_valid = 1'b1; in_dmac = d; in_smac = s; in_port = PORT_W'(p);
        @(negedge clk);
        check(req, "fwd_valid", longint'(fwd_valid), 1);
        check(req, "fwd_hit",   longint'(fwd_hit), longint'(eh));
        check(req, "fwd_flood", longint'(fwd_flood), longint'(!eh));
        check(req, "fwd_port",  longint'(fwd_port), longint'(ep));
    endtask

    task automatic idle(int n, logic [47:0] junk);
        in_valid = 1'b0; in_dmac = junk; in_smac = junk; in_port = 4'd2;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R2", "fwd_valid idle", longint'(fwd_valid), 0);
        end
    endtask

    function automatic logic [47:0] st(int i);
        return 48'h0200_0000_0000 + 48'(i);
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
        m_rr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", "fwd_valid after reset", longint'(fwd_valid), 0);
        send("R1 R4", st(100), st(101), 1);
        idle(1, 48'h0);
    endtask

    task automatic t_learn_forward();
        send("R4", st(200), st(1), 3);
        send("R3 R5", st(1), st(2), 5);     // back-to-back: sees previous learn
        send("R3", st(2), st(3), 6);
        idle(1, 48'h0);
    endtask

    task automatic t_same_slot();
        send("R9", st(4), st(4), 7);         // learn and look up same address
        send("R9 R3", st(4), st(5), 8);
        idle(1, 48'h0);
    endtask

    task automatic t_move_and_same();
        send("R7", st(300), st(1), 9);
        send("R7 R3", st(1), st(300), 9);
        send("R6", st(2), st(2), 5);
        send("R6 R3", st(2), st(300), 9);
        idle(1, 48'h0);
    endtask

    task automatic t_idle_ignored();
        idle(3, st(400));
        send("R10", st(400), st(5), 8);
        idle(1, 48'h0);
    endtask

    task automatic t_fill_and_replace();
        for (int i = 10; i < 10 + DEPTH + 20; i++) begin
            send("R5 R8", st(i - 1), st(i), i % 16);
        end
        for (int i = 0; i < 50; i++) begin
            send("R8", st(i), st(1000), 3);
        end
        idle(1, 48'h0);
    endtask

    initial begin
        #500us;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_learn_forward();
        t_same_slot();
        t_move_and_same();
        t_idle_ignored();
        t_fill_and_replace();
        finish_run();
    end
endmodule